// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the register-write front end of one programmable interrupt controller. Software talks to it through two byte-wide write ports that share one data bus. One is the command port, selected by `cmd_we`. The other is the data port, selected by `data_we`. A byte written to the command port with bit 4 set always starts a new initialization. The data port then takes the second, third and fourth initialization words. The third and fourth words are skipped according to the mode bits of the first word.

Once initialization is finished, the sequencer is ready. A data-port byte then loads the interrupt mask. A command-port byte is decoded as one of two operation words:
- the first operation word carries end-of-interrupt commands;
- the second operation word carries read and mode selections.

The block keeps every word it has accepted. It reports end-of-interrupt commands as a one-cycle pulse, together with a type code and a level. It also flags two kinds of misuse:
- command bytes that are out of place;
- data-port writes that arrive before any initialization.

Request latching, priority resolution, cascading and vector delivery belong to neighbouring blocks that consume these outputs.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the sequencer is uninitialized (`ready`=0), and every stored word, the mask and all pulses are 0.
- R2: A command-port byte with bit 4 = 1 is stored as the first init word in any state. The sequencer then expects the second init word (`ready`=0).
- R3: After the second init word, the sequencer expects the third init word when bit 1 of the first word is 0 (cascade). When bit 1 is 1 (single), it goes straight to the R4 decision.
- R4: At the R4 decision, the sequencer expects the fourth init word when bit 0 of the first word is 1. Otherwise it becomes ready.
- R5: A data-port byte received while the fourth init word is expected is stored as that word, and the sequencer becomes ready.
- R6: When ready, each data-port byte loads the mask (`imr`). The mask changes at no other time.
- R7: When ready, a command-port byte with bits 4:3 = 00 is stored in `ocw2_q`, and one with bits 4:3 = 01 is stored in `ocw3_q`.
- R8: An `ocw2_q` byte with bit 5 (EOI) = 1, bit 7 (rotate) = 0 and bit 6 (specific) = 1 pulses `eoi_pulse`. `eoi_level` then equals bits 2:0.
- R9: An `ocw2_q` byte with EOI = 1, rotate = 0 and specific = 0 pulses `eoi_pulse` with `eoi_level` = 0.
- R10: Every `ocw2_q` byte sets `eoi_kind` = {bit 7, bit 6, bit 5}. A byte with rotate = 1 gives no `eoi_pulse`.
- R11: A command-port byte with bit 4 = 0 written while not ready pulses `bad_cmd` for one cycle. The byte stores nothing and leaves the state unchanged.
- R12: A data-port byte written while uninitialized pulses `seq_err` for one cycle and stores nothing.
- R13: When both strobes are high in one cycle, only the command-port write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command port |
| data_we | input | 1 | Write strobe for the data port |
| wdata | input | 8 | Write data shared by both ports |
| icw1_q | output | 8 | Stored first init word |
| icw2_q | output | 8 | Stored second init word |
| icw3_q | output | 8 | Stored third init word |
| icw4_q | output | 8 | Stored fourth init word |
| imr | output | 8 | Interrupt mask |
| ocw2_q | output | 8 | Last end-of-interrupt/rotate operation word |
| ocw3_q | output | 8 | Last read/mode operation word |
| ready | output | 1 | Initialization complete |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt pulse |
| eoi_kind | output | 3 | {rotate, specific, EOI} of the last `ocw2_q` byte |
| eoi_level | output | 3 | Level of a specific EOI, 0 otherwise |
| bad_cmd | output | 1 | One-cycle pulse for a misplaced command byte |
| seq_err | output | 1 | One-cycle pulse for a data write before initialization |

## Verification
Each result is registered once, so a write sampled at one rising edge shows up on every output just after that edge. That covers the stored words, `ready`, `eoi_pulse`, `eoi_kind`, `eoi_level`, `bad_cmd` and `seq_err`. The pulses drop again one edge later. The bench drives strobes on the falling edge and clears them on the next falling edge. It samples at that second falling edge, half a cycle after the edge that took the write. To show that a pulse lasts only one cycle, it waits one more idle cycle and checks that the pulse is gone. Skipped steps and ignored writes are checked through the stored words and `ready`.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_ICW2   = 3'd1,
    ST_ICW3   = 3'd2,
    ST_ICW4   = 3'd3,
    ST_READY  = 3'd4
  } seq_st_e;

  // slots of the word register bank
  localparam int SLOT_ICW1 = 0;
  localparam int SLOT_ICW2 = 1;
  localparam int SLOT_ICW3 = 2;
  localparam int SLOT_ICW4 = 3;
  localparam int SLOT_IMR  = 4;
  localparam int SLOT_OCW2 = 5;
  localparam int SLOT_OCW3 = 6;
  localparam int NUM_SLOTS = 7;

  function automatic logic is_init_word(input logic [7:0] b);
    return b[4];
  endfunction

  function automatic logic is_eoi_word(input logic [7:0] b);
    return (b[4:3] == 2'b00);
  endfunction

  function automatic logic is_mode_word(input logic [7:0] b);
    return (b[4:3] == 2'b01);
  endfunction

  // step after the third word (or after the second in single mode)
  function automatic seq_st_e step_after_third(input logic [7:0] first);
    return first[0] ? ST_ICW4 : ST_READY;
  endfunction

  // step after the second word: cascade mode needs the third word
  function automatic seq_st_e step_after_second(input logic [7:0] first);
    return (!first[1]) ? ST_ICW3 : step_after_third(first);
  endfunction

  // end-of-interrupt fires only for non-rotating commands
  function automatic logic eoi_fires(input logic [7:0] b);
    return b[5] & ~b[7];
  endfunction

  function automatic logic [2:0] eoi_target(input logic [7:0] b);
    return b[6] ? b[2:0] : 3'd0;
  endfunction

endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] icw1_q,
  output seq_st_e           st_q,
  output logic [NUM_SLOTS-1:0] ld_vec,
  output logic              eoi_word_ev,
  output logic              bad_cmd_ev,
  output logic              seq_err_ev
);

  seq_st_e st_d;
  logic    dwr;

  // the command port wins when both strobes are high
  assign dwr = data_we & ~cmd_we;

  always_comb begin
    st_d        = st_q;
    ld_vec      = '0;
    eoi_word_ev = 1'b0;
    bad_cmd_ev  = 1'b0;
    seq_err_ev  = 1'b0;
    if (cmd_we) begin
      if (is_init_word(wdata[7:0])) begin
        ld_vec[SLOT_ICW1] = 1'b1;
        st_d              = ST_ICW2;
      end else if (st_q == ST_READY) begin
        if (is_eoi_word(wdata[7:0])) begin
          ld_vec[SLOT_OCW2] = 1'b1;
          eoi_word_ev       = 1'b1;
        end else if (is_mode_word(wdata[7:0])) begin
          ld_vec[SLOT_OCW3] = 1'b1;
        end else begin
          bad_cmd_ev = 1'b1;
        end
      end else begin
        bad_cmd_ev = 1'b1;
      end
    end else if (dwr) begin
      unique case (st_q)
        ST_ICW2: begin
          ld_vec[SLOT_ICW2] = 1'b1;
          st_d              = step_after_second(icw1_q[7:0]);
        end
        ST_ICW3: begin
          ld_vec[SLOT_ICW3] = 1'b1;
          st_d              = step_after_third(icw1_q[7:0]);
        end
        ST_ICW4: begin
          ld_vec[SLOT_ICW4] = 1'b1;
          st_d              = ST_READY;
        end
        ST_READY: ld_vec[SLOT_IMR] = 1'b1;
        default:  seq_err_ev = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_UNINIT;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/pic_word_regs.sv
module pic_word_regs #(
  parameter int W = 8,
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ld_vec,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] words [N]
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         words[g] <= '0;
      else if (ld_vec[g]) words[g] <= wdata;
    end
  end

endmodule

// File: rtl/pic_eoi_gen.sv
module pic_eoi_gen
  import pic_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eoi_word_ev,
  input  logic              bad_cmd_ev,
  input  logic              seq_err_ev,
  input  logic [DATA_W-1:0] wdata,
  output logic              eoi_pulse,
  output logic [2:0]        eoi_kind,
  output logic [LVL_W-1:0]  eoi_level,
  output logic              bad_cmd,
  output logic              seq_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_pulse <= 1'b0;
      eoi_kind  <= '0;
      eoi_level <= '0;
      bad_cmd   <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      bad_cmd   <= bad_cmd_ev;
      seq_err   <= seq_err_ev;
      eoi_pulse <= eoi_word_ev & eoi_fires(wdata[7:0]);
      if (eoi_word_ev) begin
        eoi_kind  <= wdata[7:5];
        eoi_level <= LVL_W'(eoi_target(wdata[7:0]));
      end
    end
  end

endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] icw1_q,
  output logic [DATA_W-1:0] icw2_q,
  output logic [DATA_W-1:0] icw3_q,
  output logic [DATA_W-1:0] icw4_q,
  output logic [DATA_W-1:0] imr,
  output logic [DATA_W-1:0] ocw2_q,
  output logic [DATA_W-1:0] ocw3_q,
  output logic              ready,
  output logic              eoi_pulse,
  output logic [2:0]        eoi_kind,
  output logic [LVL_W-1:0]  eoi_level,
  output logic              bad_cmd,
  output logic              seq_err
);

  seq_st_e              st_q;
  logic [NUM_SLOTS-1:0] ld_vec;
  logic                 eoi_word_ev;
  logic                 bad_cmd_ev;
  logic                 seq_err_ev;
  logic [DATA_W-1:0]    words [NUM_SLOTS];

  pic_init_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .data_we     (data_we),
    .wdata       (wdata),
    .icw1_q      (icw1_q),
    .st_q        (st_q),
    .ld_vec      (ld_vec),
    .eoi_word_ev (eoi_word_ev),
    .bad_cmd_ev  (bad_cmd_ev),
    .seq_err_ev  (seq_err_ev)
  );

  pic_word_regs #(.W(DATA_W), .N(NUM_SLOTS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_vec (ld_vec),
    .wdata  (wdata),
    .words  (words)
  );

  pic_eoi_gen #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_eoi (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoi_word_ev (eoi_word_ev),
    .bad_cmd_ev  (bad_cmd_ev),
    .seq_err_ev  (seq_err_ev),
    .wdata       (wdata),
    .eoi_pulse   (eoi_pulse),
    .eoi_kind    (eoi_kind),
    .eoi_level   (eoi_level),
    .bad_cmd     (bad_cmd),
    .seq_err     (seq_err)
  );

  assign icw1_q = words[SLOT_ICW1];
  assign icw2_q = words[SLOT_ICW2];
  assign icw3_q = words[SLOT_ICW3];
  assign icw4_q = words[SLOT_ICW4];
  assign imr    = words[SLOT_IMR];
  assign ocw2_q = words[SLOT_OCW2];
  assign ocw3_q = words[SLOT_OCW3];
  assign ready  = (st_q == ST_READY);

endmodule

// File: rtl/pic_seq_chk.sv
module pic_seq_chk #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic              data_we,
  input logic [DATA_W-1:0] wdata,
  input logic [2:0]        st_q,
  input logic              ready,
  input logic [DATA_W-1:0] icw1_q,
  input logic [DATA_W-1:0] imr,
  input logic              eoi_pulse,
  input logic [LVL_W-1:0]  eoi_level,
  input logic              bad_cmd,
  input logic              seq_err
);

  // R2
  init_word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && wdata[4]) |=> (icw1_q == $past(wdata)) && !ready);

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && data_we && !cmd_we) |=> (imr == $past(wdata)));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && data_we && !cmd_we) |=> $stable(imr));

  // R8
  eoi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(cmd_we && ready && (wdata[4:3] == 2'b00)
                        && wdata[5] && !wdata[7]));

  // R8
  eoi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && $past(wdata[6])) |-> (eoi_level == $past(wdata[2:0])));

  // R11
  bad_cmd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |-> $past(cmd_we && !wdata[4] && !ready));

  // R12
  seq_err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(data_we && !cmd_we && (st_q == 3'd0)));

endmodule

bind pic_cmd_seq pic_seq_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_we    (cmd_we),
  .data_we   (data_we),
  .wdata     (wdata),
  .st_q      (st_q),
  .ready     (ready),
  .icw1_q    (icw1_q),
  .imr       (imr),
  .eoi_pulse (eoi_pulse),
  .eoi_level (eoi_level),
  .bad_cmd   (bad_cmd),
  .seq_err   (seq_err)
);

// File: tb/pic_cmd_seq_test.sv
module pic_cmd_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic       data_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] icw1_q, icw2_q, icw3_q, icw4_q, imr, ocw2_q, ocw3_q;
  logic       ready, eoi_pulse, bad_cmd, seq_err;
  logic [2:0] eoi_kind, eoi_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .data_we(data_we), .wdata(wdata),
    .icw1_q(icw1_q), .icw2_q(icw2_q), .icw3_q(icw3_q), .icw4_q(icw4_q),
    .imr(imr), .ocw2_q(ocw2_q), .ocw3_q(ocw3_q), .ready(ready),
    .eoi_pulse(eoi_pulse), .eoi_kind(eoi_kind), .eoi_level(eoi_level),
    .bad_cmd(bad_cmd), .seq_err(seq_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one write; returns at the falling edge after the capturing edge
  task automatic wr(input bit to_cmd, input bit to_data, input logic [7:0] v);
    @(negedge clk);
    cmd_we  = to_cmd;
    data_we = to_data;
    wdata   = v;
    @(negedge clk);
    cmd_we  = 1'b0;
    data_we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready", {7'd0, ready}, 8'h00);
    chk("R1 imr", imr, 8'h00);
    chk("R1 icw1", icw1_q, 8'h00);
    chk("R1 ocw2", ocw2_q, 8'h00);
    chk("R1 pulses", {5'd0, eoi_pulse, bad_cmd, seq_err}, 8'h00);
  endtask

  task automatic t_early_writes();
    wr(0, 1, 8'h55);
    chk("R12 seq_err pulse", {7'd0, seq_err}, 8'h01);
    chk("R12 imr untouched", imr, 8'h00);
    chk("R12 icw2 untouched", icw2_q, 8'h00);
    idle();
    chk("R12 seq_err one cycle", {7'd0, seq_err}, 8'h00);
    wr(1, 0, 8'h20);
    chk("R11 bad_cmd uninit", {7'd0, bad_cmd}, 8'h01);
    chk("R11 ocw2 untouched", ocw2_q, 8'h00);
    idle();
    chk("R11 bad_cmd one cycle", {7'd0, bad_cmd}, 8'h00);
  endtask

  task automatic t_cascade_ic4();
    wr(1, 0, 8'h11);
    chk("R2 icw1 stored", icw1_q, 8'h11);
    chk("R2 not ready", {7'd0, ready}, 8'h00);
    wr(1, 0, 8'h08);
    chk("R11 bad_cmd mid-init", {7'd0, bad_cmd}, 8'h01);
    chk("R11 ocw3 untouched", ocw3_q, 8'h00);
    wr(0, 1, 8'h20);
    chk("R3 icw2 stored", icw2_q, 8'h20);
    chk("R3 cascade waits", {7'd0, ready}, 8'h00);
    wr(0, 1, 8'h04);
    chk("R3 icw3 stored", icw3_q, 8'h04);
    chk("R4 ic4 waits", {7'd0, ready}, 8'h00);
    wr(0, 1, 8'h01);
    chk("R5 icw4 stored", icw4_q, 8'h01);
    chk("R5 ready", {7'd0, ready}, 8'h01);
    chk("R5 no seq_err", {7'd0, seq_err}, 8'h00);
  endtask

  task automatic t_ready_words();
    wr(0, 1, 8'hA5);
    chk("R6 imr load", imr, 8'hA5);
    wr(1, 0, 8'h08);
    chk("R7 ocw3 stored", ocw3_q, 8'h08);
    chk("R6 imr held", imr, 8'hA5);
    wr(1, 0, 8'h63);
    chk("R7 ocw2 stored", ocw2_q, 8'h63);
    chk("R8 eoi pulse", {7'd0, eoi_pulse}, 8'h01);
    chk("R8 eoi level", {5'd0, eoi_level}, 8'h03);
    chk("R10 kind specific", {5'd0, eoi_kind}, 8'h03);
    idle();
    chk("R8 pulse one cycle", {7'd0, eoi_pulse}, 8'h00);
    wr(1, 0, 8'h27);
    chk("R9 eoi pulse", {7'd0, eoi_pulse}, 8'h01);
    chk("R9 level zero", {5'd0, eoi_level}, 8'h00);
    chk("R10 kind nonspecific", {5'd0, eoi_kind}, 8'h01);
    wr(1, 0, 8'hE5);
    chk("R10 rotate no pulse", {7'd0, eoi_pulse}, 8'h00);
    chk("R10 kind rotate", {5'd0, eoi_kind}, 8'h07);
    chk("R10 ocw2 stored", ocw2_q, 8'hE5);
    chk("R11 no bad_cmd ready", {7'd0, bad_cmd}, 8'h00);
  endtask

  task automatic t_skips();
    wr(1, 0, 8'h12);
    chk("R2 reinit from ready", {7'd0, ready}, 8'h00);
    chk("R6 imr kept on reinit", imr, 8'hA5);
    wr(0, 1, 8'h40);
    chk("R4 single no ic4 ready", {7'd0, ready}, 8'h01);
    chk("R3 icw3 skipped", icw3_q, 8'h04);
    chk("R4 icw4 skipped", icw4_q, 8'h01);
    wr(0, 1, 8'h0F);
    chk("R6 imr after skip", imr, 8'h0F);
    wr(1, 0, 8'h13);
    wr(0, 1, 8'h48);
    chk("R4 single ic4 waits", {7'd0, ready}, 8'h00);
    chk("R3 icw3 not loaded", icw3_q, 8'h04);
    wr(0, 1, 8'h03);
    chk("R5 icw4 single", icw4_q, 8'h03);
    chk("R5 ready single", {7'd0, ready}, 8'h01);
    wr(1, 0, 8'h10);
    wr(0, 1, 8'h50);
    chk("R3 cascade no ic4 waits", {7'd0, ready}, 8'h00);
    wr(0, 1, 8'h07);
    chk("R3 icw3 loaded", icw3_q, 8'h07);
    chk("R4 ready without icw4", {7'd0, ready}, 8'h01);
    chk("R4 icw4 kept", icw4_q, 8'h03);
  endtask

  task automatic t_both_ports();
    wr(1, 1, 8'h0A);
    chk("R13 command taken", ocw3_q, 8'h0A);
    chk("R13 imr ignored", imr, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_early_writes();
    t_cascade_ic4();
    t_ready_words();
    t_skips();
    t_both_ports();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule